// File: doc/BRIEF.md
# JTAG Chain Host Sequencer

This block is the host end of a boundary test port. It drives the test clock, the mode select line and the serial data line, and it samples the serial return line, for a daisy chain of identical devices. By default the chain has three devices, each with a 3-bit instruction register. A command port accepts three operations. The first is a chain reset. The second loads an instruction into one chosen device and puts every other device into bypass. The third scans an 8-bit value through the chosen device's data register. A scan returns the 8 bits captured from that register.

The engine follows the state of the whole chain from the mode-select paths it has issued. Devices are numbered from the return-line end: device 0 is nearest the return line and device N-1 is nearest the data output. Every serial stream goes out least-significant bit first, so the bits meant for device 0 are shifted first. The test clock comes from a divider of the system clock. Mode select and data change as the test clock falls, and the return line is sampled as it rises. The test clock is held low whenever no command is running.

Top module: `jtag_chain_seq`

## Requirements
- R1: After rst_ni is released, busy_o, done_o, tck_o, tms_o and tdi_o are 0 and rdata_o is 0.
- R2: Command code 0 (reset) drives tms_o high on 5 consecutive test-clock rising edges. This leaves every device in the Test-Logic-Reset state.
- R3: Each high phase of tck_o lasts HALF_DIV system clocks. tms_o and tdi_o do not change while tck_o is high. tck_o stays low while busy_o is 0.
- R4: Command code 1 (instruction load) shifts N_DEV*IR_W bits. The target device (cmd_tgt_i, 0 = nearest tdo_i) receives cmd_ir_i, and every other device receives the bypass code 3'b110. Each field goes out LSB first, starting with device 0.
- R5: Command code 2 (data scan) shifts N_DEV-1+DR_W bits: cmd_tgt_i padding zeros, then cmd_data_i LSB first, then the remaining padding zeros. The target's data register ends up holding cmd_data_i, and the other devices' data registers are unchanged.
- R6: After a data scan, rdata_o holds the 8 bits that the target's data register held before the scan. The bits returned from bypass positions are discarded.
- R7: To enter a shift state, the engine uses mode-select path 0,1,1,0,0 (instruction) or 0,1,0,0 (data) when the chain is in Test-Logic-Reset, and 1,1,0,0 or 1,0,0 when it is in Run-Test/Idle. tms_o is 1 on the last shift bit, and the sequence 1,0 that follows leaves the chain in Run-Test/Idle.
- R8: A command is taken only while busy_o is 0, and cmd_valid_i is ignored while busy_o is 1. At completion, done_o pulses high for exactly one cycle, and busy_o falls in that same cycle.
- R9: Command code 3 is ignored: busy_o stays 0 and no test clock is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 reset, 1 instruction load, 2 data scan, 3 none |
| cmd_tgt_i | input | 2 | Target device index, 0 nearest tdo_i |
| cmd_ir_i | input | 3 | Instruction for the target |
| cmd_data_i | input | 8 | Data to write into the target's data register |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Bits captured from the target by the last data scan |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Mode select |
| tdi_o | output | 1 | Serial data toward the chain |
| tdo_i | input | 1 | Serial data returned by the chain |

## Verification
The hardest case is getting the entry path wrong only for the chain's tracked state. An engine that always assumed Test-Logic-Reset, or always assumed Run-Test/Idle, would still pass half the commands. The stimulus therefore mixes instruction loads issued straight after a reset with ones issued straight after an earlier scan, and it inserts random resets. A bench model of the chain, driven only by the pins, checks each device's instruction and data registers after every command. Read-back at the outer bypass positions is exercised by directed scans to targets 0 and 2, and a command raised mid-sequence tests that a busy engine drops it.

// File: rtl/jcs_pkg.sv
package jcs_pkg;
  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IR    = 2'd1,
    OP_DR    = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_SHIFT,
    ST_POST
  } st_e;
endpackage

// File: rtl/jcs_tck_gen.sv
module jcs_tck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int DW = $clog2(HALF_DIV + 1);

  logic [DW-1:0] cnt_q;
  logic          tck_q;
  logic          wrap;

  assign wrap   = (cnt_q == DW'(HALF_DIV - 1));
  assign rise_o = run_i && wrap && !tck_q;
  assign fall_o = run_i && wrap && tck_q;
  assign tck_o  = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !tck_o);
  a_r3_rise_goes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> tck_o);
endmodule

// File: rtl/jcs_vec_build.sv
module jcs_vec_build
  import jcs_pkg::*;
#(
  parameter int               N_DEV    = 3,
  parameter int               IR_W     = 3,
  parameter int               DR_W     = 8,
  parameter int               TGT_W    = 2,
  parameter int               SHIFT_W  = 10,
  parameter int               CNT_W    = 4,
  parameter logic [IR_W-1:0]  BYP_CODE = 3'b110
) (
  input  op_e                op_i,
  input  logic [TGT_W-1:0]   tgt_i,
  input  logic [IR_W-1:0]    ir_i,
  input  logic [DR_W-1:0]    data_i,
  output logic [SHIFT_W-1:0] vec_o,
  output logic [CNT_W-1:0]   len_o
);
  localparam int IR_LEN = N_DEV * IR_W;
  localparam int DR_LEN = N_DEV - 1 + DR_W;

  logic [IR_LEN-1:0]  ir_flat;
  logic [SHIFT_W-1:0] ir_full;
  logic [SHIFT_W-1:0] dr_full;

  for (genvar d = 0; d < N_DEV; d++) begin : g_dev
    assign ir_flat[d*IR_W +: IR_W] = (tgt_i == TGT_W'(d)) ? ir_i : BYP_CODE;
  end

  always_comb begin
    ir_full = '0;
    ir_full[IR_LEN-1:0] = ir_flat;
    dr_full = '0;
    dr_full[DR_W-1:0] = data_i;
    dr_full = dr_full << tgt_i;
  end

  always_comb begin
    vec_o = '0;
    len_o = '0;
    case (op_i)
      OP_IR: begin
        vec_o = ir_full;
        len_o = CNT_W'(IR_LEN);
      end
      OP_DR: begin
        vec_o = dr_full;
        len_o = CNT_W'(DR_LEN);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/jcs_capture.sv
module jcs_capture #(
  parameter int DR_W    = 8,
  parameter int TGT_W   = 2,
  parameter int SHIFT_W = 10,
  parameter int CNT_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             tdo_i,
  input  logic             latch_i,
  input  logic [TGT_W-1:0] tgt_i,
  output logic [DR_W-1:0]  rdata_o
);
  logic [SHIFT_W-1:0] cap_q;
  logic [SHIFT_W-1:0] cap_sh;
  logic [DR_W-1:0]    rdata_q;

  for (genvar i = 0; i < SHIFT_W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cap_q[i] <= 1'b0;
      else if (smp_i && idx_i == CNT_W'(i))    cap_q[i] <= tdo_i;
    end
  end

  assign cap_sh = cap_q >> tgt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (latch_i) rdata_q <= cap_sh[DR_W-1:0];
  end

  assign rdata_o = rdata_q;

  a_r6_read_only_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(rdata_o));
endmodule

// File: rtl/jcs_ctrl.sv
module jcs_ctrl
  import jcs_pkg::*;
#(
  parameter int TGT_W   = 2,
  parameter int SHIFT_W = 10,
  parameter int CNT_W   = 4,
  parameter int RST_LEN = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  op_e                cmd_op_i,
  input  logic [TGT_W-1:0]   cmd_tgt_i,
  input  logic [SHIFT_W-1:0] vec_i,
  input  logic [CNT_W-1:0]   len_i,
  input  logic               tck_i,
  input  logic               rise_i,
  input  logic               fall_i,
  output logic               run_o,
  output logic               tms_o,
  output logic               tdi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               smp_o,
  output logic               latch_o,
  output logic [CNT_W-1:0]   idx_o,
  output logic [TGT_W-1:0]   tgt_o
);
  // entry paths, first bit in bit 0
  localparam logic [7:0] PRE_IR_TLR = 8'b0000_0110;
  localparam logic [7:0] PRE_IR_RTI = 8'b0000_0011;
  localparam logic [7:0] PRE_DR_TLR = 8'b0000_0010;
  localparam logic [7:0] PRE_DR_RTI = 8'b0000_0001;

  st_e                st_q;
  op_e                op_q;
  logic [TGT_W-1:0]   tgt_q;
  logic [7:0]         pre_q;
  logic [CNT_W-1:0]   plen_q;
  logic [SHIFT_W-1:0] svec_q;
  logic [CNT_W-1:0]   slen_q;
  logic [CNT_W-1:0]   idx_q;
  logic               at_tlr_q;
  logic               done_q;
  logic               accept;
  logic               pre_last, shift_last, post_last, fin;

  assign accept     = (st_q == ST_IDLE) && cmd_valid_i && (cmd_op_i != OP_NONE);
  assign pre_last   = (idx_q == plen_q - 1'b1);
  assign shift_last = (idx_q == slen_q - 1'b1);
  assign post_last  = (idx_q == CNT_W'(1));
  assign fin        = fall_i && (((st_q == ST_PRE) && (op_q == OP_RESET) && pre_last) ||
                                 ((st_q == ST_POST) && post_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      op_q     <= OP_RESET;
      tgt_q    <= '0;
      pre_q    <= '0;
      plen_q   <= '0;
      svec_q   <= '0;
      slen_q   <= '0;
      idx_q    <= '0;
      at_tlr_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      case (st_q)
        ST_IDLE: if (accept) begin
          op_q   <= cmd_op_i;
          tgt_q  <= cmd_tgt_i;
          svec_q <= vec_i;
          slen_q <= len_i;
          idx_q  <= '0;
          st_q   <= ST_PRE;
          case (cmd_op_i)
            OP_IR: begin
              pre_q  <= at_tlr_q ? PRE_IR_TLR : PRE_IR_RTI;
              plen_q <= at_tlr_q ? CNT_W'(5) : CNT_W'(4);
            end
            OP_DR: begin
              pre_q  <= at_tlr_q ? PRE_DR_TLR : PRE_DR_RTI;
              plen_q <= at_tlr_q ? CNT_W'(4) : CNT_W'(3);
            end
            default: begin
              pre_q  <= '1;
              plen_q <= CNT_W'(RST_LEN);
            end
          endcase
        end
        ST_PRE: if (fall_i) begin
          pre_q <= pre_q >> 1;
          if (pre_last) begin
            idx_q <= '0;
            if (op_q == OP_RESET) begin
              st_q     <= ST_IDLE;
              at_tlr_q <= 1'b1;
            end else begin
              st_q <= ST_SHIFT;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_SHIFT: if (fall_i) begin
          svec_q <= svec_q >> 1;
          if (shift_last) begin
            idx_q <= '0;
            st_q  <= ST_POST;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_POST: if (fall_i) begin
          if (post_last) begin
            idx_q    <= '0;
            st_q     <= ST_IDLE;
            at_tlr_q <= 1'b0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tms_o = 1'b0;
    tdi_o = 1'b0;
    case (st_q)
      ST_PRE:   tms_o = (op_q == OP_RESET) ? 1'b1 : pre_q[0];
      ST_SHIFT: begin
        tms_o = shift_last;
        tdi_o = svec_q[0];
      end
      ST_POST:  tms_o = (idx_q == '0);
      default:  ;
    endcase
  end

  assign run_o   = (st_q != ST_IDLE);
  assign busy_o  = run_o;
  assign done_o  = done_q;
  assign smp_o   = rise_i && (st_q == ST_SHIFT) && (op_q == OP_DR);
  assign latch_o = fin && (op_q == OP_DR);
  assign idx_o   = idx_q;
  assign tgt_o   = tgt_q;

  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_busy_drops_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r8_no_take_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i) |=> ($stable(op_q) && $stable(tgt_q)));
  a_r3_pins_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tck_i && $past(tck_i)) |-> ($stable(tms_o) && $stable(tdi_o)));
  a_r7_exit_on_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_POST) && ($past(st_q) == ST_SHIFT)) |-> $past(tms_o));
  a_r9_reserved_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && cmd_valid_i && (cmd_op_i == OP_NONE)) |=> !busy_o);
endmodule

// File: rtl/jtag_chain_seq.sv
module jtag_chain_seq
  import jcs_pkg::*;
#(
  parameter int              N_DEV    = 3,
  parameter int              IR_W     = 3,
  parameter int              DR_W     = 8,
  parameter int              HALF_DIV = 2,
  parameter int              RST_LEN  = 5,
  parameter logic [IR_W-1:0] BYP_CODE = 3'b110,
  localparam int             TGT_W    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [TGT_W-1:0] cmd_tgt_i,
  input  logic [IR_W-1:0]  cmd_ir_i,
  input  logic [DR_W-1:0]  cmd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DR_W-1:0]  rdata_o,
  output logic             tck_o,
  output logic             tms_o,
  output logic             tdi_o,
  input  logic             tdo_i
);
  localparam int IR_LEN  = N_DEV * IR_W;
  localparam int DR_LEN  = N_DEV - 1 + DR_W;
  localparam int SHIFT_W = (IR_LEN > DR_LEN) ? IR_LEN : DR_LEN;
  localparam int LEN_A   = (SHIFT_W > RST_LEN) ? SHIFT_W : RST_LEN;
  localparam int LEN_MAX = (LEN_A > 5) ? LEN_A : 5;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);

  op_e                op;
  logic [SHIFT_W-1:0] vec;
  logic [CNT_W-1:0]   len;
  logic               run, rise, fall, smp, latch;
  logic [CNT_W-1:0]   idx;
  logic [TGT_W-1:0]   tgt;

  assign op = op_e'(cmd_op_i);

  jcs_vec_build #(
    .N_DEV(N_DEV), .IR_W(IR_W), .DR_W(DR_W), .TGT_W(TGT_W),
    .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .BYP_CODE(BYP_CODE)
  ) u_build (
    .op_i(op), .tgt_i(cmd_tgt_i), .ir_i(cmd_ir_i), .data_i(cmd_data_i),
    .vec_o(vec), .len_o(len)
  );

  jcs_tck_gen #(.HALF_DIV(HALF_DIV)) u_tck (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run),
    .tck_o(tck_o), .rise_o(rise), .fall_o(fall)
  );

  jcs_ctrl #(
    .TGT_W(TGT_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(op),
    .cmd_tgt_i(cmd_tgt_i), .vec_i(vec), .len_i(len), .tck_i(tck_o),
    .rise_i(rise), .fall_i(fall), .run_o(run), .tms_o(tms_o), .tdi_o(tdi_o),
    .busy_o(busy_o), .done_o(done_o), .smp_o(smp), .latch_o(latch),
    .idx_o(idx), .tgt_o(tgt)
  );

  jcs_capture #(
    .DR_W(DR_W), .TGT_W(TGT_W), .SHIFT_W(SHIFT_W), .CNT_W(CNT_W)
  ) u_cap (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .idx_i(idx), .tdo_i(tdo_i),
    .latch_i(latch), .tgt_i(tgt), .rdata_o(rdata_o)
  );

  a_r1_idle_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !tck_o);
endmodule

// File: tb/jtag_chain_seq_bench.sv
module jtag_chain_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam logic [2:0] BYP = 3'b110;
  localparam logic [2:0] SEL = 3'b010;

  localparam int TLR = 0, RTI = 1, SELDR = 2, CAPDR = 3, SHDR = 4, EX1DR = 5, PAUDR = 6,
                 EX2DR = 7, UPDDR = 8, SELIR = 9, CAPIR = 10, SHIR = 11, EX1IR = 12,
                 PAUIR = 13, EX2IR = 14, UPDIR = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [1:0] cmd_tgt = 2'd0;
  logic [2:0] cmd_ir = 3'd0;
  logic [7:0] cmd_data = 8'd0;
  logic       busy, done, tck, tms, tdi, tdo;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtag_chain_seq u_jtag_chain_seq (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_tgt_i(cmd_tgt), .cmd_ir_i(cmd_ir), .cmd_data_i(cmd_data),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .tck_o(tck), .tms_o(tms),
    .tdi_o(tdi), .tdo_i(tdo)
  );

  // chain model, driven only by the pins
  int         m_st = PAUDR;
  logic [2:0] m_ir[3];
  logic [2:0] m_irsr[3];
  logic [7:0] m_dreg[3];
  logic [7:0] m_drsr[3];
  logic       m_byp[3];
  logic       m_tdo = 1'b0;
  int         m_ones = 0;
  logic [7:0] exp_dreg[3];

  assign tdo = m_tdo;

  function automatic int tap_next(int s, logic t);
    case (s)
      TLR:   return t ? TLR   : RTI;
      RTI:   return t ? SELDR : RTI;
      SELDR: return t ? SELIR : CAPDR;
      CAPDR: return t ? EX1DR : SHDR;
      SHDR:  return t ? EX1DR : SHDR;
      EX1DR: return t ? UPDDR : PAUDR;
      PAUDR: return t ? EX2DR : PAUDR;
      EX2DR: return t ? UPDDR : SHDR;
      UPDDR: return t ? SELDR : RTI;
      SELIR: return t ? TLR   : CAPIR;
      CAPIR: return t ? EX1IR : SHIR;
      SHIR:  return t ? EX1IR : SHIR;
      EX1IR: return t ? UPDIR : PAUIR;
      PAUIR: return t ? EX2IR : PAUIR;
      EX2IR: return t ? UPDIR : SHIR;
      default: return t ? SELDR : RTI;
    endcase
  endfunction

  always @(posedge tck) begin
    logic din, dout;
    m_ones = tms ? m_ones + 1 : 0;
    din = tdi;
    case (m_st)
      TLR:   for (int d = 0; d < 3; d++) m_ir[d] = BYP;
      CAPIR: for (int d = 0; d < 3; d++) m_irsr[d] = 3'b001;
      SHIR:  for (int d = 2; d >= 0; d--) begin
               dout = m_irsr[d][0];
               m_irsr[d] = {din, m_irsr[d][2:1]};
               din = dout;
             end
      UPDIR: for (int d = 0; d < 3; d++) m_ir[d] = m_irsr[d];
      CAPDR: for (int d = 0; d < 3; d++)
               if (m_ir[d] == SEL) m_drsr[d] = m_dreg[d]; else m_byp[d] = 1'b0;
      SHDR:  for (int d = 2; d >= 0; d--) begin
               if (m_ir[d] == SEL) begin
                 dout = m_drsr[d][0];
                 m_drsr[d] = {din, m_drsr[d][7:1]};
               end else begin
                 dout = m_byp[d];
                 m_byp[d] = din;
               end
               din = dout;
             end
      UPDDR: for (int d = 0; d < 3; d++) if (m_ir[d] == SEL) m_dreg[d] = m_drsr[d];
      default: ;
    endcase
    m_st = tap_next(m_st, tms);
  end

  always @(negedge tck) begin
    if (m_st == SHIR)      m_tdo = m_irsr[0][0];
    else if (m_st == SHDR) m_tdo = (m_ir[0] == SEL) ? m_drsr[0][0] : m_byp[0];
    else                   m_tdo = 1'b0;
  end

  // pin-timing monitors (R3, R8), sampled away from the active edge
  int   viol_r3 = 0, viol_r8 = 0, hi_run = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0, p_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck && p_tck && (tms !== p_tms || tdi !== p_tdi)) viol_r3++;
      if (tck && !busy) viol_r3++;
      if (tck) hi_run++;
      else begin
        if (p_tck && hi_run != HALF) viol_r3++;
        hi_run = 0;
      end
      if (done && p_done) viol_r8++;
      if (done && busy) viol_r8++;
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi; p_done = done;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic issue(input logic [1:0] op, input logic [1:0] t, input logic [2:0] ir,
                       input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_tgt = t; cmd_ir = ir; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, {req, " completion"}, int'(done), 1);
    @(negedge clk);
  endtask

  task automatic do_reset();
    issue(2'd0, 2'd0, 3'd0, 8'd0);
    wait_done("R2");
    chk(m_st == TLR, "R2 chain in reset state", m_st, TLR);
    chk(m_ones >= 5, "R2 tms high count", m_ones, 5);
  endtask

  task automatic do_ir(input logic [1:0] t, input logic [2:0] code, input string req);
    issue(2'd1, t, code, 8'd0);
    wait_done(req);
    for (int d = 0; d < 3; d++) begin
      logic [2:0] e;
      e = (d == int'(t)) ? code : BYP;
      chk(m_ir[d] === e, {req, " R4 device instruction"}, int'(m_ir[d]), int'(e));
    end
    chk(m_st == RTI, {req, " R7 parked in idle"}, m_st, RTI);
  endtask

  task automatic do_dr(input logic [1:0] t, input logic [7:0] d, input string req);
    issue(2'd2, t, 3'd0, d);
    wait_done(req);
    chk(rdata === exp_dreg[t], {req, " R6 read-back"}, int'(rdata), int'(exp_dreg[t]));
    exp_dreg[t] = d;
    for (int k = 0; k < 3; k++)
      chk(m_dreg[k] === exp_dreg[k], {req, " R5 data register"}, int'(m_dreg[k]),
          int'(exp_dreg[k]));
    chk(m_st == RTI, {req, " R7 parked in idle"}, m_st, RTI);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd7331);
    m_dreg[0] = 8'h5A; m_dreg[1] = 8'hC3; m_dreg[2] = 8'h96;
    for (int d = 0; d < 3; d++) begin
      exp_dreg[d] = m_dreg[d];
      m_ir[d] = 3'b111; m_irsr[d] = 3'b000; m_drsr[d] = 8'h00; m_byp[d] = 1'b0;
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(done === 1'b0, "R1 done", int'(done), 0);
    chk(tck === 1'b0 && tms === 1'b0 && tdi === 1'b0, "R1 pins", int'({tck, tms, tdi}), 0);
    chk(rdata === 8'h00, "R1 rdata", int'(rdata), 0);

    // R2 then R7 entry from reset state
    do_reset();
    do_ir(2'd1, SEL, "R7 from reset");
    do_dr(2'd1, 8'hF5, "R5 middle");
    // R7 entry from idle
    do_ir(2'd0, SEL, "R7 from idle");
    do_dr(2'd0, 8'hA5, "R6 target0");
    do_ir(2'd2, SEL, "R4 target2");
    do_dr(2'd2, 8'h81, "R6 target2");
    do_dr(2'd2, 8'h7E, "R6 repeat target2");

    // R9 reserved code
    begin
      int st0;
      st0 = m_st;
      issue(2'd3, 2'd1, 3'd5, 8'hFF);
      repeat (12) @(negedge clk);
      chk(busy === 1'b0 && tck === 1'b0, "R9 no sequence", int'({busy, tck}), 0);
      chk(m_st == st0, "R9 chain untouched", m_st, st0);
    end

    // R8 command while busy is dropped
    issue(2'd2, 2'd2, 3'd0, 8'h3C);
    repeat (6) @(negedge clk);
    chk(busy === 1'b1, "R8 busy during scan", int'(busy), 1);
    issue(2'd1, 2'd0, 3'b111, 8'd0);
    wait_done("R8");
    chk(rdata === exp_dreg[2], "R8 R6 read-back", int'(rdata), int'(exp_dreg[2]));
    exp_dreg[2] = 8'h3C;
    repeat (8) @(negedge clk);
    chk(busy === 1'b0, "R8 second command dropped", int'(busy), 0);
    chk(m_ir[0] === BYP && m_ir[2] === SEL, "R8 instructions kept",
        int'({m_ir[0], m_ir[2]}), int'({BYP, SEL}));

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      logic [1:0] t, u;
      logic [2:0] code;
      t = 2'($urandom_range(0, 2));
      u = 2'($urandom_range(0, 2));
      code = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) do_reset();
      do_ir(u, code, "R4 random");
      do_ir(t, SEL, "R7 random");
      do_dr(t, 8'($urandom_range(0, 255)), "R5 random");
    end

    chk(viol_r3 == 0, "R3 tck phase and pin hold", viol_r3, 0);
    chk(viol_r8 == 0, "R8 done pulse shape", viol_r8, 0);
    summary();
    $finish;
  end
endmodule